// File: doc/BRIEF.md
# 8x8 Hybrid Inverse Transform Reconstructor

This block rebuilds one 8x8 block of pixels from its transform coefficients. It applies a separable 2D inverse transform to 64 signed 16-bit coefficients, adds the result to an 8x8 block of 8-bit prediction pixels and writes clipped 8-bit pixels. Each direction can use an 8-point inverse DCT or an 8-point inverse ADST. A 2-bit type code makes the choice independently for the horizontal pass and the vertical pass.

A block starts with a one-cycle `start` that captures the type and mode. The block then takes eight coefficient rows, one row per beat. Each row passes through the horizontal kernel as it arrives and is stored in an in-place 64-entry transpose buffer. Eight vertical passes follow, one column per cycle. The block then takes eight prediction rows, and each accepted prediction row yields one reconstructed row.

Two fast modes exist. The first transforms only the upper four coefficient rows. The second, a DC-only mode, skips both passes and adds one offset to all 64 pixels.

Top module: `hyt_recon8x8`

## Requirements
- R1: `tx_type` bit 1 set selects the ADST for the horizontal (row) pass and bit 0 set selects it for the vertical (column) pass; a clear bit selects the DCT. The codes are: 0 = DCT both ways, 1 = vertical ADST with horizontal DCT, 2 = vertical DCT with horizontal ADST, 3 = ADST both ways.
- R2: Coefficient rows arrive in row-major order, with element i of a beat at bits [16i+15:16i]. Each row is transformed horizontally and its results are kept as 16-bit two's-complement values. Each column of those results is then transformed vertically, and its results are also kept as 16-bit values. Both passes round every multiply by 2^-14 as (x + 8192) >>> 14.
- R3: Each pixel is the clip to 0..255 of the prediction pixel plus ((v + 16) >>> 5), where v is the vertical-pass result. Pixel i of a pixel beat sits at bits [8i+7:8i].
- R4: With `mode` = 1 (quadrant mode), coefficient rows 4 to 7 are accepted but act as all-zero rows, whatever their content.
- R5: With `mode` = 2 (DC-only), d = rs(rs(c0 * 11585) * 11585), where rs(x) = (x + 8192) >>> 14 and c0 is element 0 of the first coefficient row. The offset (d + 16) >>> 5 is added to all 64 pixels with saturation at 0 and 255. All other coefficients and the type are ignored. Mode 0 and mode 3 both mean the full transform.
- R6: `start` is accepted only while no block is in progress. `coef_ready` stays high until eight coefficient beats have been accepted, and `pred_ready` stays high until eight prediction beats have been accepted. A `start` during a block has no effect.
- R7: `out_valid` rises with `out_row` exactly one cycle after each accepted prediction beat, and the rows come out in order 0 to 7.
- R8: `done` is high for exactly the one cycle that carries the eighth output row, and at no other time.
- R9: `tx_type` and `mode` are sampled at `start`. Changes to them later in the block have no effect on its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a block (taken when idle) |
| tx_type | input | 2 | Transform type per direction |
| mode | input | 2 | 0/3 full, 1 quadrant, 2 DC-only |
| coef_valid | input | 1 | Coefficient row present |
| coef_ready | output | 1 | Coefficient row accepted this cycle if valid |
| coef_row | input | 128 | Eight signed 16-bit coefficients |
| pred_valid | input | 1 | Prediction row present |
| pred_ready | output | 1 | Prediction row accepted this cycle if valid |
| pred_row | input | 64 | Eight 8-bit prediction pixels |
| out_valid | output | 1 | Reconstructed row present |
| out_row | output | 64 | Eight 8-bit reconstructed pixels |
| done | output | 1 | Last row of the block |

## Verification
A reconstructed row is due on the first rising edge after its prediction beat is accepted, and `done` is due with the eighth such row. The monitor therefore samples at the falling edge that follows each acceptance and pops one expected row per `out_valid` from a queue the driver filled before the block began. Prediction beats are spaced with idle gaps, so an output that came a cycle late or early would be paired with the wrong row or would appear with an empty queue. The prediction phase can start only after the coefficient beats and the eight column cycles have finished (or right after the coefficient beats in DC-only mode). The driver waits on the ready outputs, so the pass latencies affect only pacing and never the comparison.

// File: rtl/hyt_pkg.sv
// Shared parameters, types and arithmetic for the 8x8 reconstructor.
// Assumes an 8-point transform; only the data widths are free.
package hyt_pkg;
    parameter int LANES  = 8;
    parameter int COEF_W = 16;
    parameter int PIX_W  = 8;
    localparam int IDX_W   = $clog2(LANES);
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef logic [LANES-1:0][COEF_W-1:0] vec_t;
    typedef logic [LANES-1:0][PIX_W-1:0]  pix_t;

    typedef enum logic [1:0] {S_IDLE, S_ROWS, S_COLS, S_OUTS} phase_t;

    localparam logic [1:0] MODE_QUAD = 2'd1;
    localparam logic [1:0] MODE_DC   = 2'd2;

    // Trig constants: round(16384 * cos(k*pi/64)) for the k in use.
    localparam int C2  = 16305, C4  = 16069, C6  = 15679, C8  = 15137;
    localparam int C10 = 14449, C12 = 13623, C14 = 12665, C16 = 11585;
    localparam int C18 = 10394, C20 = 9102,  C22 = 7723,  C24 = 6270;
    localparam int C26 = 4756,  C28 = 3196,  C30 = 1606;

    // Round-to-nearest scale by 2^-14.
    function automatic int rs14(input int x);
        return (x + 8192) >>> 14;
    endfunction

    function automatic int sx(input logic [COEF_W-1:0] w);
        return int'($signed(w));
    endfunction

    // 8-point inverse DCT, butterfly form.
    function automatic vec_t idct8(input vec_t d);
        int p0, p1, p2, p3, q0, q1, q2, q3;
        int a4, a5, a6, a7, b4, b5, b6, b7;
        vec_t o;
        p0 = rs14((sx(d[0]) + sx(d[4])) * C16);
        p1 = rs14((sx(d[0]) - sx(d[4])) * C16);
        p2 = rs14(sx(d[2]) * C24 - sx(d[6]) * C8);
        p3 = rs14(sx(d[2]) * C8 + sx(d[6]) * C24);
        q0 = p0 + p3; q3 = p0 - p3;
        q1 = p1 + p2; q2 = p1 - p2;
        a4 = rs14(sx(d[1]) * C28 - sx(d[7]) * C4);
        a7 = rs14(sx(d[1]) * C4 + sx(d[7]) * C28);
        a5 = rs14(sx(d[5]) * C12 - sx(d[3]) * C20);
        a6 = rs14(sx(d[5]) * C20 + sx(d[3]) * C12);
        b5 = rs14((a7 - a6 - a4 + a5) * C16);
        b6 = rs14((a4 - a5 - a6 + a7) * C16);
        b4 = a4 + a5;
        b7 = a6 + a7;
        o[0] = COEF_W'(q0 + b7); o[7] = COEF_W'(q0 - b7);
        o[1] = COEF_W'(q1 + b6); o[6] = COEF_W'(q1 - b6);
        o[2] = COEF_W'(q2 + b5); o[5] = COEF_W'(q2 - b5);
        o[3] = COEF_W'(q3 + b4); o[4] = COEF_W'(q3 - b4);
        return o;
    endfunction

    // 8-point inverse ADST, three rotation stages with output sign flips.
    function automatic vec_t iadst8(input vec_t d);
        int s0, s1, s2, s3, s4, s5, s6, s7;
        int y0, y1, y2, y3, y4, y5, y6, y7;
        int z4, z5, z6, z7;
        vec_t o;
        s0 = C2 * sx(d[7]) + C30 * sx(d[0]);
        s1 = C30 * sx(d[7]) - C2 * sx(d[0]);
        s2 = C10 * sx(d[5]) + C22 * sx(d[2]);
        s3 = C22 * sx(d[5]) - C10 * sx(d[2]);
        s4 = C18 * sx(d[3]) + C14 * sx(d[4]);
        s5 = C14 * sx(d[3]) - C18 * sx(d[4]);
        s6 = C26 * sx(d[1]) + C6 * sx(d[6]);
        s7 = C6 * sx(d[1]) - C26 * sx(d[6]);
        y0 = rs14(s0 + s4); y4 = rs14(s0 - s4);
        y1 = rs14(s1 + s5); y5 = rs14(s1 - s5);
        y2 = rs14(s2 + s6); y6 = rs14(s2 - s6);
        y3 = rs14(s3 + s7); y7 = rs14(s3 - s7);
        s4 = C8 * y4 + C24 * y5;
        s5 = C24 * y4 - C8 * y5;
        s6 = C8 * y7 - C24 * y6;
        s7 = C8 * y6 + C24 * y7;
        z4 = rs14(s4 + s6); z6 = rs14(s4 - s6);
        z5 = rs14(s5 + s7); z7 = rs14(s5 - s7);
        o[0] = COEF_W'(y0 + y2);
        o[7] = COEF_W'(-(y1 + y3));
        o[1] = COEF_W'(-z4);
        o[6] = COEF_W'(z5);
        o[3] = COEF_W'(-rs14(C16 * ((y0 - y2) + (y1 - y3))));
        o[4] = COEF_W'(rs14(C16 * ((y0 - y2) - (y1 - y3))));
        o[2] = COEF_W'(rs14(C16 * (z6 + z7)));
        o[5] = COEF_W'(-rs14(C16 * (z6 - z7)));
        return o;
    endfunction
endpackage

// File: rtl/hyt_kernel8.sv
// 1D inverse transform kernel shared by the row and column passes.
// Purely combinational; the caller picks DCT or ADST per pass.
module hyt_kernel8
    import hyt_pkg::*;
(
    input  logic adst,
    input  vec_t din,
    output vec_t dout
);
    // Select the transform variant for this pass.
    always_comb begin
        dout = adst ? iadst8(din) : idct8(din);
    end
endmodule

// File: rtl/hyt_tbuf.sv
// 8x8 transpose buffer of COEF_W entries, used in place. A whole row is
// written during the row pass. During the column pass each column is read
// and then overwritten with its vertical result. Assumes the two write
// ports are never active in the same cycle.
module hyt_tbuf
    import hyt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_we,
    input  logic [IDX_W-1:0] row_idx,
    input  vec_t             row_wdata,
    input  logic             col_we,
    input  logic [IDX_W-1:0] col_idx,
    input  vec_t             col_wdata,
    output vec_t             col_rdata,
    input  logic [IDX_W-1:0] rd_row_idx,
    output vec_t             row_rdata
);
    vec_t mem [LANES];

    // Store a row or a column of results.
    always_ff @(posedge clk) begin
        if (row_we) begin
            mem[row_idx] <= row_wdata;
        end else if (col_we) begin
            for (int r = 0; r < LANES; r++) mem[r][col_idx] <= col_wdata[r];
        end
    end

    // Read one column for the vertical pass and one row for output.
    always_comb begin
        for (int r = 0; r < LANES; r++) col_rdata[r] = mem[r][col_idx];
        row_rdata = mem[rd_row_idx];
    end

    AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_we && col_we)); // R2
endmodule

// File: rtl/hyt_recon_row.sv
// Final stage for one row: rounds each residual by (v+16)>>>5, adds it to
// the prediction pixel and clips to 0..PIX_MAX. In DC-only mode every lane
// uses the same broadcast value in place of the buffered residual.
module hyt_recon_row
    import hyt_pkg::*;
(
    input  pix_t pred,
    input  vec_t res,
    input  logic dc_en,
    input  int   dc_val,
    output pix_t pix
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        int v, r, s;
        logic [PIX_W-1:0] p;

        // Round, add and saturate one lane, then check the clip direction.
        always_comb begin
            v = dc_en ? dc_val : sx(res[g]);
            r = (v + 16) >>> 5;
            s = r + int'(pred[g]);
            if (s < 0)            p = '0;
            else if (s > PIX_MAX) p = PIX_W'(PIX_MAX);
            else                  p = PIX_W'(s);
            if (r >= 0) begin
                AST_CLIP_UP: assert (p >= pred[g]); // R3
            end else begin
                AST_CLIP_DOWN: assert (p <= pred[g]); // R3
            end
        end
        assign pix[g] = p;
    end
endmodule

// File: rtl/hyt_recon8x8.sv
// 8x8 hybrid inverse transform and reconstruction controller.
// Phases: accept 8 coefficient rows (horizontal pass into the buffer), run
// 8 column cycles (vertical pass, in place), then accept 8 prediction rows
// and emit one reconstructed row per beat. DC-only mode skips the column
// cycles. Assumes the next start comes only after done.
module hyt_recon8x8
    import hyt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             tx_type,
    input  logic [1:0]             mode,
    input  logic                   coef_valid,
    output logic                   coef_ready,
    input  logic [LANES*COEF_W-1:0] coef_row,
    input  logic                   pred_valid,
    output logic                   pred_ready,
    input  logic [LANES*PIX_W-1:0] pred_row,
    output logic                   out_valid,
    output logic [LANES*PIX_W-1:0] out_row,
    output logic                   done
);
    phase_t           state;
    logic [IDX_W-1:0] cnt;
    logic [1:0]       type_q, mode_q;
    int               dc_q;
    vec_t             coef_vec, kin, kout, col_rd, row_rd, row_wd;
    pix_t             pix;
    logic             last;

    assign coef_vec   = coef_row;
    assign coef_ready = (state == S_ROWS);
    assign pred_ready = (state == S_OUTS);
    assign last       = (cnt == IDX_W'(LANES - 1));

    // Feed the kernel from the input row or the buffered column.
    always_comb begin
        kin = (state == S_COLS) ? col_rd : coef_vec;
    end

    // Quadrant mode turns the lower four rows into zero rows.
    always_comb begin
        row_wd = (mode_q == MODE_QUAD && cnt[IDX_W-1]) ? '0 : kout;
    end

    hyt_kernel8 u_kernel (
        .adst (state == S_COLS ? type_q[0] : type_q[1]),
        .din  (kin),
        .dout (kout)
    );

    hyt_tbuf u_tbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_we     (state == S_ROWS && coef_valid),
        .row_idx    (cnt),
        .row_wdata  (row_wd),
        .col_we     (state == S_COLS),
        .col_idx    (cnt),
        .col_wdata  (kout),
        .col_rdata  (col_rd),
        .rd_row_idx (cnt),
        .row_rdata  (row_rd)
    );

    hyt_recon_row u_recon (
        .pred   (pred_row),
        .res    (row_rd),
        .dc_en  (mode_q == MODE_DC),
        .dc_val (dc_q),
        .pix    (pix)
    );

    // Phase sequencing, sampled controls and registered output row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            type_q    <= '0;
            mode_q    <= '0;
            dc_q      <= 0;
            out_valid <= 1'b0;
            out_row   <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    type_q <= tx_type;
                    mode_q <= mode;
                    cnt    <= '0;
                    state  <= S_ROWS;
                end
                S_ROWS: if (coef_valid) begin
                    if (cnt == '0) dc_q <= rs14(rs14(sx(coef_vec[0]) * C16) * C16);
                    cnt <= cnt + 1'b1;
                    if (last) state <= (mode_q == MODE_DC) ? S_OUTS : S_COLS;
                end
                S_COLS: begin
                    cnt <= cnt + 1'b1;
                    if (last) state <= S_OUTS;
                end
                S_OUTS: if (pred_valid) begin
                    out_valid <= 1'b1;
                    out_row   <= pix;
                    cnt       <= cnt + 1'b1;
                    if (last) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(type_q) && $stable(mode_q))); // R9
    AST_ROW_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pred_valid && pred_ready)); // R7
    AST_DONE_ON_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && state == S_IDLE)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
endmodule

// File: tb/tb_hyt_recon8x8.sv
// Scoreboard bench: the driver computes each block's expected rows from an
// integer reference model and queues them; the monitor pops one per out_valid.
module tb_hyt_recon8x8;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] tx_type = '0, mode = '0;
    logic coef_valid = 1'b0, pred_valid = 1'b0;
    logic coef_ready, pred_ready, out_valid, done;
    logic [127:0] coef_row = '0;
    logic [63:0]  pred_row = '0, out_row;

    hyt_recon8x8 dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_type(tx_type), .mode(mode),
        .coef_valid(coef_valid), .coef_ready(coef_ready), .coef_row(coef_row),
        .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_row(pred_row),
        .out_valid(out_valid), .out_row(out_row), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0, m_cmp = 0, m_bad = 0, rows_seen = 0;
    logic [63:0] exp_q[$];
    string tag_q[$];
    int coef[64];
    int pred[64];

    function automatic int cv(input int k);
        case (k)
            2: return 16305;  4: return 16069;  6: return 15679;  8: return 15137;
            10: return 14449; 12: return 13623; 14: return 12665; 16: return 11585;
            18: return 10394; 20: return 9102;  22: return 7723;  24: return 6270;
            26: return 4756;  28: return 3196;  30: return 1606;
            default: return 0;
        endcase
    endfunction

    function automatic int rnd(input int x);
        return (x + 8192) >>> 14;
    endfunction

    function automatic int clip8(input int x);
        return (x < 0) ? 0 : (x > 255) ? 255 : x;
    endfunction

    // Reference inverse DCT.
    function automatic void m_idct(input int i[8], output int o[8]);
        int e0, e1, e2, e3, f4, f5, f6, f7, g5, g6;
        e0 = rnd((i[0] + i[4]) * cv(16));
        e1 = rnd((i[0] - i[4]) * cv(16));
        e2 = rnd(i[2] * cv(24) - i[6] * cv(8));
        e3 = rnd(i[2] * cv(8) + i[6] * cv(24));
        f4 = rnd(i[1] * cv(28) - i[7] * cv(4));
        f7 = rnd(i[1] * cv(4) + i[7] * cv(28));
        f5 = rnd(i[5] * cv(12) - i[3] * cv(20));
        f6 = rnd(i[5] * cv(20) + i[3] * cv(12));
        g5 = rnd((f7 - f6 - f4 + f5) * cv(16));
        g6 = rnd((f4 - f5 - f6 + f7) * cv(16));
        o[0] = (e0 + e3) + (f6 + f7); o[7] = (e0 + e3) - (f6 + f7);
        o[1] = (e1 + e2) + g6;        o[6] = (e1 + e2) - g6;
        o[2] = (e1 - e2) + g5;        o[5] = (e1 - e2) - g5;
        o[3] = (e0 - e3) + (f4 + f5); o[4] = (e0 - e3) - (f4 + f5);
    endfunction

    // Reference inverse ADST.
    function automatic void m_iadst(input int i[8], output int o[8]);
        int x[8], s[8], t[8];
        x = '{i[7], i[0], i[5], i[2], i[3], i[4], i[1], i[6]};
        s[0] = cv(2) * x[0] + cv(30) * x[1];  s[1] = cv(30) * x[0] - cv(2) * x[1];
        s[2] = cv(10) * x[2] + cv(22) * x[3]; s[3] = cv(22) * x[2] - cv(10) * x[3];
        s[4] = cv(18) * x[4] + cv(14) * x[5]; s[5] = cv(14) * x[4] - cv(18) * x[5];
        s[6] = cv(26) * x[6] + cv(6) * x[7];  s[7] = cv(6) * x[6] - cv(26) * x[7];
        for (int k = 0; k < 4; k++) begin
            x[k] = rnd(s[k] + s[k+4]);
            x[k+4] = rnd(s[k] - s[k+4]);
        end
        t[4] = cv(8) * x[4] + cv(24) * x[5];  t[5] = cv(24) * x[4] - cv(8) * x[5];
        t[6] = -cv(24) * x[6] + cv(8) * x[7]; t[7] = cv(8) * x[6] + cv(24) * x[7];
        t[0] = x[0] + x[2]; t[1] = x[1] + x[3]; t[2] = x[0] - x[2]; t[3] = x[1] - x[3];
        x[4] = rnd(t[4] + t[6]); x[5] = rnd(t[5] + t[7]);
        x[6] = rnd(t[4] - t[6]); x[7] = rnd(t[5] - t[7]);
        o[0] = t[0];                        o[7] = -t[1];
        o[1] = -x[4];                       o[6] = x[5];
        o[2] = rnd(cv(16) * (x[6] + x[7])); o[5] = -rnd(cv(16) * (x[6] - x[7]));
        o[3] = -rnd(cv(16) * (t[2] + t[3])); o[4] = rnd(cv(16) * (t[2] - t[3]));
    endfunction

    function automatic void m_1d(input bit adst, input int i[8], output int o[8]);
        if (adst) m_iadst(i, o); else m_idct(i, o);
    endfunction

    // Build the 8 expected rows for the current coef/pred arrays (R1..R5).
    task automatic push_expected(input int tt, input int md, input string tag);
        int mid[8][8], res[8][8], vi[8], vo[8], a;
        logic [63:0] row;
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 8; k++) vi[k] = (md == 1 && r >= 4) ? 0 : coef[r*8+k];
            m_1d(tt[1], vi, vo);
            for (int k = 0; k < 8; k++) mid[r][k] = int'(shortint'(vo[k]));
        end
        for (int k = 0; k < 8; k++) begin
            for (int r = 0; r < 8; r++) vi[r] = mid[r][k];
            m_1d(tt[0], vi, vo);
            for (int r = 0; r < 8; r++) res[r][k] = int'(shortint'(vo[r]));
        end
        a = (rnd(rnd(coef[0] * cv(16)) * cv(16)) + 16) >>> 5;
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 8; k++)
                row[8*k +: 8] = 8'(clip8(pred[r*8+k] +
                    ((md == 2) ? a : ((res[r][k] + 16) >>> 5))));
            exp_q.push_back(row);
            tag_q.push_back(tag);
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input int amp, input int pmin, input int pmax);
        for (int i = 0; i < 64; i++) begin
            coef[i] = int'($urandom_range(0, 2 * amp)) - amp;
            pred[i] = int'($urandom_range(pmin, pmax));
        end
    endtask

    // Drive one block; disturb toggles start/type/mode mid-block (R6, R9).
    task automatic run_block(input int tt, input int md, input bit disturb, input string tag);
        push_expected(tt, md, tag);
        @(negedge clk);
        start = 1'b1; tx_type = 2'(tt); mode = 2'(md);
        @(negedge clk);
        start = 1'b0;
        check(coef_ready == 1'b1, "R6 coef_ready after start", int'(coef_ready), 1);
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 8; k++) coef_row[16*k +: 16] = 16'(coef[r*8+k]);
            coef_valid = 1'b1;
            if (disturb) begin
                start = 1'b1; tx_type = ~2'(tt); mode = 2'(md) ^ 2'd3;
            end
            while (!coef_ready) @(negedge clk);
            @(negedge clk);
        end
        coef_valid = 1'b0;
        start = 1'b0;
        for (int r = 0; r < 8; r++) begin
            if (r % 3 == 1) begin
                pred_valid = 1'b0;
                @(negedge clk);
            end
            for (int k = 0; k < 8; k++) pred_row[8*k +: 8] = 8'(pred[r*8+k]);
            pred_valid = 1'b1;
            while (!pred_ready) @(negedge clk);
            @(negedge clk);
        end
        pred_valid = 1'b0;
        check(pred_ready == 1'b0 && coef_ready == 1'b0, "R6 idle after block",
              int'({coef_ready, pred_ready}), 0);
    endtask

    // Monitor: one expected row per out_valid (R7), done only on row 7 (R8).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (out_valid) begin
                    m_cmp++;
                    if (exp_q.size() == 0) begin
                        m_bad++;
                        $display("FAIL R7 unexpected row actual=%h expected=none", out_row);
                    end else begin
                        logic [63:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (out_row !== e) begin
                            m_bad++;
                            $display("FAIL %s row %0d actual=%h expected=%h",
                                     t, rows_seen % 8, out_row, e);
                        end
                    end
                    m_cmp++;
                    if (done !== (rows_seen % 8 == 7)) begin
                        m_bad++;
                        $display("FAIL R8 done on row %0d actual=%0b expected=%0b",
                                 rows_seen % 8, done, rows_seen % 8 == 7);
                    end
                    rows_seen++;
                end else if (done) begin
                    m_cmp++;
                    m_bad++;
                    $display("FAIL R8 done without row actual=1 expected=0");
                end
            end
        end
    end

    initial begin
        bit timeout;
        timeout = 1'b0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                check(!out_valid && !done && !coef_ready && !pred_ready, "R6 reset state",
                      int'({out_valid, done, coef_ready, pred_ready}), 0);
                for (int i = 0; i < 64; i++) begin coef[i] = 0; pred[i] = 7 + i; end
                run_block(0, 0, 1'b0, "R3 zero coefficients pass prediction");
                for (int t = 0; t < 4; t++) begin
                    fill(150, 0, 255);
                    run_block(t, 0, 1'b0, "R1 R2 type sweep");
                    fill(60, 40, 215);
                    run_block(t, 0, 1'b0, "R1 R2 type sweep small");
                end
                fill(400, 0, 255);
                run_block(3, 0, 1'b0, "R3 saturation full transform");
                fill(200, 0, 255);
                run_block(0, 1, 1'b0, "R4 quadrant dct");
                fill(200, 0, 255);
                run_block(3, 1, 1'b0, "R4 quadrant adst");
                fill(200, 200, 255);
                coef[0] = 8000;
                run_block(3, 2, 1'b0, "R5 dc positive saturate");
                fill(200, 0, 40);
                coef[0] = -8000;
                run_block(1, 2, 1'b0, "R5 dc negative saturate");
                fill(200, 0, 255);
                run_block(1, 3, 1'b0, "R5 mode 3 full");
                fill(150, 0, 255);
                run_block(2, 0, 1'b1, "R9 R6 controls ignored mid-block");
                repeat (5) @(negedge clk);
                check(exp_q.size() == 0, "R7 all rows delivered", exp_q.size(), 0);
            end
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) check(1'b0, "watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp, n_bad + m_bad);
        $finish;
    end
endmodule